// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block moves a block of words between one I/O device port and memory so that the processor does not handle each word. Software programs a direction, a device select value, a first memory address and a word count, then writes a go bit. After that the processor keeps running. The engine fetches or delivers each word on its own.

The engine takes the system bus one word at a time. For every word it raises a bus request only when the device side is able to take part. It waits for the grant and performs a single one-clock bus cycle, then drops the request at once. The processor therefore stalls for at most one bus clock per word, and only when it needs the bus at that moment. Each word crosses the bus once, directly between the device port and memory. When the last word has been moved the engine raises a level interrupt, which software clears through the status register.

Top module: `dma_steal`

## Requirements
- R1: After reset, busReq, busValid, busWe, devRdReady, devWrValid and irq are 0, and the status register (offset 4) reads 0.
- R2: Register offsets on regAddr: 0 = control (bit0 go, bit1 direction, 1 = memory to device, 0 = device to memory), 1 = device select, 2 = memory address, 3 = word count, 4 = status (bit0 busy, bit1 done). Reads return the current values, zero-extended.
- R3: Each word uses exactly one bus cycle. busValid is high for one clock, only while busReq and busGnt are both high, and busReq is low in the next clock.
- R4: busReq rises only while a transfer is active and the device side is ready: devRdValid for device to memory, devWrReady for memory to device. Once raised, busReq stays high until busGnt is seen.
- R5: The words use consecutive memory addresses from the programmed start. At the end, the memory address register reads start+N and the count register reads 0.
- R6: In the device-to-memory direction, each bus cycle is a write (busWe=1) carrying devRdData. devRdReady is high in that same clock, so the device word is consumed.
- R7: In the memory-to-device direction, each bus cycle is a read (busWe=0). The word is captured and offered on devWrValid/devWrData until devWrReady accepts it, and it reaches the device unchanged and in order.
- R8: When the last word completes, busy clears and done sets, and irq follows done. Writing 1 to status bit1 clears done and irq. A new go also clears done.
- R9: A go with a word count of 0 sets done on the next clock and raises no bus request.
- R10: While busy, writes to control, device select, memory address and count have no effect, and a second go is ignored.
- R11: The devSel output always shows the device select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data (combinational) |
| irq | output | 1 | Block-complete interrupt, level |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant |
| busValid | output | 1 | One-clock bus cycle strobe |
| busWe | output | 1 | Bus cycle is a memory write |
| busAddr | output | ADDR_W | Memory word address |
| busWdata | output | DATA_W | Memory write data |
| busRdata | input | DATA_W | Memory read data, valid in the bus cycle |
| devSel | output | DEV_W | Device select value |
| devRdValid | input | 1 | Device has a word for memory |
| devRdData | input | DATA_W | Word from the device |
| devRdReady | output | 1 | Device word consumed |
| devWrValid | output | 1 | Word offered to the device |
| devWrData | output | DATA_W | Word to the device |
| devWrReady | input | 1 | Device accepts the offered word |

## Verification
A wrong address or count register shows up as soon as the next bus cycle. busAddr leaves the expected sequence, or the block finishes after the wrong number of words, and the memory image or the device capture differs at the end. A controller stuck in the request state, or one that holds the bus, shows on the next granted cycle as busValid high for two clocks or busReq still high after the transfer. A fault in done handling shows at irq within one clock of the last word or of the clearing write.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_PUSH
  } dmaState_t;

  typedef struct packed {
    logic step;     // advance address, decrement count
    logic capture;  // latch memory read data for the device
  } dmaStrobe_t;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_DEV  = 3'd1;
  localparam logic [2:0] OFS_MEM  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

endpackage

// File: rtl/dma_dpath.sv
module dma_dpath
  import dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              busy,
  input  logic              done,
  input  dmaStrobe_t        strb,
  output logic              startReq,
  output logic              doneClr,
  output logic              dirMemToDev,
  output logic              cntZero,
  output logic              cntOne,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] devRdData,
  output logic [DATA_W-1:0] devWrData,
  output logic [DEV_W-1:0]  devSel
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              dirReg;
  logic [DEV_W-1:0]  devReg;
  logic [ADDR_W-1:0] memAddrReg;
  logic [CNT_W-1:0]  cntReg;
  logic [DATA_W-1:0] holdReg;
  logic              cfgWe;

  assign cfgWe    = regWe && !busy;
  assign startReq = cfgWe && (regAddr == OFS_CTRL) && regWdata[0];
  assign doneClr  = regWe && (regAddr == OFS_STAT) && regWdata[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg     <= 1'b0;
      devReg     <= '0;
      memAddrReg <= '0;
      cntReg     <= '0;
      holdReg    <= '0;
    end else begin
      if (cfgWe) begin
        case (regAddr)
          OFS_CTRL: dirReg     <= regWdata[1];
          OFS_DEV:  devReg     <= regWdata[DEV_W-1:0];
          OFS_MEM:  memAddrReg <= regWdata[ADDR_W-1:0];
          OFS_CNT:  cntReg     <= regWdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (strb.step) begin
        memAddrReg <= memAddrReg + 1'b1;
        cntReg     <= cntReg - 1'b1;
      end
      if (strb.capture) holdReg <= busRdata;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CTRL: regRdata = REG_W'({dirReg, 1'b0});
      OFS_DEV:  regRdata = REG_W'(devReg);
      OFS_MEM:  regRdata = REG_W'(memAddrReg);
      OFS_CNT:  regRdata = REG_W'(cntReg);
      OFS_STAT: regRdata = REG_W'({done, busy});
      default:  regRdata = '0;
    endcase
  end

  assign dirMemToDev = dirReg;
  assign cntZero     = (cntReg == '0);
  assign cntOne      = (cntReg == CNT_ONE);
  assign busAddr     = memAddrReg;
  assign busWdata    = devRdData;
  assign devWrData   = holdReg;
  assign devSel      = devReg;

  // R5: each step moves the count down by exactly one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> cntReg == $past(cntReg) - 1'b1);

  // R5: each step moves the address up by exactly one
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> memAddrReg == $past(memAddrReg) + 1'b1);

  // R10: configuration is frozen while a block is in flight
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(devReg) && $stable(dirReg));

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       doneClr,
  input  logic       dirMemToDev,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       busGnt,
  input  logic       devRdValid,
  input  logic       devWrReady,
  output logic       busReq,
  output logic       busValid,
  output logic       busWe,
  output logic       devRdReady,
  output logic       devWrValid,
  output logic       busy,
  output logic       done,
  output dmaStrobe_t strb
);

  dmaState_t state, stNext;
  logic setDone;
  logic devSideReady;

  assign devSideReady = dirMemToDev ? devWrReady : devRdValid;

  always_comb begin
    stNext       = state;
    setDone      = 1'b0;
    strb         = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (cntZero) setDone = 1'b1;
          else         stNext  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (devSideReady) stNext = ST_REQ;
      end
      ST_REQ: begin
        if (busGnt) begin
          strb.step = 1'b1;
          if (dirMemToDev) begin
            strb.capture = 1'b1;
            stNext       = ST_PUSH;
          end else if (cntOne) begin
            setDone = 1'b1;
            stNext  = ST_IDLE;
          end else begin
            stNext = ST_WAIT;
          end
        end
      end
      ST_PUSH: begin
        if (devWrReady) begin
          if (cntZero) begin
            setDone = 1'b1;
            stNext  = ST_IDLE;
          end else begin
            stNext = ST_WAIT;
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stNext;
      if (setDone)                done <= 1'b1;
      else if (doneClr || startReq) done <= 1'b0;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign busReq     = (state == ST_REQ);
  assign busValid   = busReq && busGnt;
  assign busWe      = busValid && !dirMemToDev;
  assign devRdReady = busValid && !dirMemToDev;
  assign devWrValid = (state == ST_PUSH);

  // R3: a bus cycle lasts one clock and the request is gone afterwards
  a_r3_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> !busValid && !busReq);

  // R4: a request is held until the grant arrives
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGnt |=> busReq);

  // R8: done and busy are never both set
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: finishing a block raises done on the following clock
  a_r8_done_rise: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

// File: rtl/dma_steal.sv
module dma_steal
  import dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              irq,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busValid,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DEV_W-1:0]  devSel,
  input  logic              devRdValid,
  input  logic [DATA_W-1:0] devRdData,
  output logic              devRdReady,
  output logic              devWrValid,
  output logic [DATA_W-1:0] devWrData,
  input  logic              devWrReady
);

  dmaStrobe_t strb;
  logic startReq, doneClr, dirMemToDev, cntZero, cntOne, busy, done;

  dma_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .doneClr     (doneClr),
    .dirMemToDev (dirMemToDev),
    .cntZero     (cntZero),
    .cntOne      (cntOne),
    .busGnt      (busGnt),
    .devRdValid  (devRdValid),
    .devWrReady  (devWrReady),
    .busReq      (busReq),
    .busValid    (busValid),
    .busWe       (busWe),
    .devRdReady  (devRdReady),
    .devWrValid  (devWrValid),
    .busy        (busy),
    .done        (done),
    .strb        (strb)
  );

  dma_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DEV_W  (DEV_W),
    .REG_W  (REG_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .busy        (busy),
    .done        (done),
    .strb        (strb),
    .startReq    (startReq),
    .doneClr     (doneClr),
    .dirMemToDev (dirMemToDev),
    .cntZero     (cntZero),
    .cntOne      (cntOne),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .devRdData   (devRdData),
    .devWrData   (devWrData),
    .devSel      (devSel)
  );

  assign irq = done;

  // R6: the device word is consumed only in a bus write cycle
  a_r6_consume_on_write: assert property (@(posedge clk) disable iff (!rstN)
    devRdReady |-> busValid && busWe && devRdValid);

  // R7: an offered device word stays until accepted
  a_r7_offer_held: assert property (@(posedge clk) disable iff (!rstN)
    devWrValid && !devWrReady |=> devWrValid && $stable(devWrData));

  // R3: bus cycles happen only under grant
  a_r3_under_grant: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busGnt);

endmodule

// File: tb/tb_dma_steal.sv
`timescale 1ns/1ps
module tb_dma_steal;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int DEV_W  = 8;
  localparam int REG_W  = 32;
  localparam real CLK_NS = 4.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [REG_W-1:0] regWdata = '0;
  logic [REG_W-1:0] regRdata;
  logic irq, busReq, busValid, busWe, devRdReady, devWrValid;
  logic busGnt = 1'b0;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata, busRdata, devRdData, devWrData;
  logic [DEV_W-1:0] devSel;
  logic devRdValid = 1'b0;
  logic devWrReady = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dma_steal #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
              .DEV_W(DEV_W), .REG_W(REG_W)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .busReq(busReq), .busGnt(busGnt), .busValid(busValid), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .devSel(devSel), .devRdValid(devRdValid), .devRdData(devRdData),
    .devRdReady(devRdReady), .devWrValid(devWrValid), .devWrData(devWrData),
    .devWrReady(devWrReady)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // models
  logic [DATA_W-1:0] mem [256];
  logic [DATA_W-1:0] srcBuf [64];
  logic [DATA_W-1:0] sinkBuf [64];
  int srcN = 0, srcIdx = 0, sinkCnt = 0;
  int gntWait = 0;
  int xferCnt = 0, addrErr = 0, widthErr = 0, reqErr = 0, reqSeen = 0;
  int curDir = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  logic prevValid = 1'b0;
  bit sinkRandom = 1;

  assign busRdata  = mem[busAddr[7:0]];
  assign devRdData = srcBuf[srcIdx[5:0]];

  always @(posedge clk) begin
    // arbiter with random grant delay
    if (busGnt) begin
      busGnt  <= 1'b0;
      gntWait <= $urandom % 4;
    end else if (busReq) begin
      if (gntWait == 0) busGnt <= 1'b1;
      else gntWait <= gntWait - 1;
    end
    // memory
    if (busValid && busWe) mem[busAddr[7:0]] <= busWdata;
    // monitors
    if (busValid) begin
      xferCnt <= xferCnt + 1;
      if (busAddr != expAddr) addrErr <= addrErr + 1;
      expAddr <= expAddr + 1'b1;
      if (busWe != (curDir == 0)) addrErr <= addrErr + 1;
    end
    if (busValid && prevValid) widthErr <= widthErr + 1;
    prevValid <= busValid;
    if (busReq) reqSeen <= reqSeen + 1;
    if (busReq && curDir == 0 && !devRdValid) reqErr <= reqErr + 1;
    // device source
    if (devRdValid && devRdReady) begin
      srcIdx     <= srcIdx + 1;
      devRdValid <= 1'b0;
    end else if (!devRdValid && srcIdx < srcN && ($urandom % 3 != 0)) begin
      devRdValid <= 1'b1;
    end
    // device sink
    if (devWrValid && devWrReady) begin
      sinkBuf[sinkCnt[5:0]] <= devWrData;
      sinkCnt <= sinkCnt + 1;
    end
    devWrReady <= sinkRandom ? ($urandom % 2 == 1) : 1'b1;
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [REG_W-1:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic waitIrq(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  // one complete block transfer; dir 0 = device to memory, 1 = memory to device
  task automatic runBlock(input int dir, input int start, input int n,
                          input bit poke);
    logic [REG_W-1:0] v;
    int bad;
    @(negedge clk);
    curDir = dir; expAddr = ADDR_W'(start);
    xferCnt = 0; addrErr = 0; widthErr = 0; reqErr = 0;
    srcIdx = 0; sinkCnt = 0; srcN = 0;
    for (int i = 0; i < 64; i++) srcBuf[i] = $urandom;
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    if (dir == 0) srcN = n;
    wrReg(3'd1, REG_W'(8'h40 + dir));
    wrReg(3'd2, REG_W'(start));
    wrReg(3'd3, REG_W'(n));
    wrReg(3'd0, REG_W'({dir[0], 1'b1}));
    if (poke) begin
      // R10: these writes land while busy and must change nothing
      wrReg(3'd2, 32'h0000_00AA);
      wrReg(3'd1, 32'h0000_0011);
      wrReg(3'd0, 32'h0000_0003);
      rdReg(3'd4, v);
      check("R10", "busy during block", v[0], 1);
    end
    check("R11", "devSel", devSel, 8'h40 + dir);
    waitIrq(4000);
    check("R8", "irq after block", irq, 1);
    rdReg(3'd4, v);
    check("R8", "status after block", v, 2);
    check("R3", "bus cycles per word", xferCnt, n);
    check("R3", "busValid width", widthErr, 0);
    check("R5", "address order", addrErr, 0);
    rdReg(3'd2, v);
    check("R5", "final memory address", v, start + n);
    rdReg(3'd3, v);
    check("R5", "final count", v, 0);
    bad = 0;
    if (dir == 0) begin
      check("R4", "request without device data", reqErr, 0);
      for (int i = 0; i < n; i++)
        if (mem[(start + i) % 256] != srcBuf[i]) bad++;
      check("R6", "memory image", bad, 0);
    end else begin
      check("R7", "device word count", sinkCnt, n);
      for (int i = 0; i < n; i++)
        if (sinkBuf[i] != mem[(start + i) % 256]) bad++;
      check("R7", "device words", bad, 0);
    end
    wrReg(3'd4, 32'h2);
    check("R8", "irq after clear", irq, 0);
  endtask

  initial begin
    logic [REG_W-1:0] v;
    process::self().srandom(32'h5eed_1234);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 64; i++) begin srcBuf[i] = '0; sinkBuf[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "irq", irq, 0);
    check("R1", "busReq", busReq, 0);
    check("R1", "busValid", busValid, 0);
    check("R1", "devRdReady/devWrValid", {devRdReady, devWrValid, busWe}, 0);
    rdReg(3'd4, v);
    check("R1", "status", v, 0);

    // R2: register read back
    wrReg(3'd1, 32'h5A);
    wrReg(3'd2, 32'h1234);
    wrReg(3'd3, 32'h0);
    wrReg(3'd0, 32'h2);
    rdReg(3'd1, v); check("R2", "device select readback", v, 32'h5A);
    rdReg(3'd2, v); check("R2", "memory address readback", v, 32'h1234);
    rdReg(3'd0, v); check("R2", "direction readback", v, 32'h2);
    check("R11", "devSel follows register", devSel, 8'h5A);

    // R9: zero count finishes at once without a request
    reqSeen = 0;
    wrReg(3'd0, 32'h1);
    check("R9", "irq on zero count", irq, 1);
    repeat (5) @(negedge clk);
    check("R9", "no bus request", reqSeen, 0);
    rdReg(3'd2, v); check("R9", "address untouched", v, 32'h1234);
    // R8: a new go clears done
    wrReg(3'd0, 32'h1);
    wrReg(3'd4, 32'h2);
    check("R8", "clear via status", irq, 0);

    // directed corners
    runBlock(0, 10, 1, 0);
    runBlock(1, 20, 1, 0);
    runBlock(0, 100, 5, 1);
    sinkRandom = 0;
    runBlock(1, 0, 8, 1);
    sinkRandom = 1;

    // random blocks
    for (int t = 0; t < 10; t++)
      runBlock($urandom % 2, $urandom % 128, 1 + $urandom % 64, t[0]);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule